// File: doc/BRIEF.md
# Two-Part TLB Lookup Engine

This block searches a translation buffer built from two arrays. The first is set-associative, with 8 ways and 16 sets, and every entry in it uses one global page size that the caller supplies. The second is a small fully associative array of 8 entries, and each of those entries carries its own page size. A lookup takes a virtual address, the current address-space identifier and the global page size. It reports whether any entry matched and, if one did, the flat index of that entry.

Each entry maps an adjacent even/odd pair of pages. The page number is therefore the address shifted right by page size plus one. The stored tag keeps address bits from bit 13 upward, so it is aligned to the page number before the compare. The lookup is a sequencer that examines one candidate per clock, started by `start_i` and finished by a one-cycle `done_o`. A separate write port fills entries by flat index so that the array can be preloaded. Permission checks and refill belong to other blocks.

Top module: `tlb_lookup`

## Requirements
- R1: After reset, done_o, hit_o and idx_o are 0 and every entry is empty, so any lookup misses.
- R2: An entry can match only if its exists bit is 1. Writing an entry with the exists bit 0 removes it from the search.
- R3: The address-space test passes when the entry's global bit is 1 or when its stored ASID equals asid_i. Otherwise the entry does not match.
- R4: In the set-associative part, the page number is va >> (gps+1). The set is the low 4 bits of the page number. An entry matches when its tag >> (gps−12) equals the page number. The reported index is way×16+set.
- R5: In the associative part, both the page number and the tag shift are computed from that entry's own page size field. The reported index is 128+i.
- R6: All 8 ways of the set-associative part are searched first. The associative part is searched only when none of those ways hits, so a hit in the set-associative part wins over any associative hit.
- R7: Within each part, the lowest-numbered matching way or entry is reported.
- R8: done_o is high for exactly one cycle, at most 16 cycles after the start is accepted. A miss reports hit_o=0 and idx_o=0. hit_o and idx_o hold their values until the next accepted start.
- R9: A start_i that arrives while a search is running is ignored: no extra done_o is produced and the running search's result is not changed.
- R10: Write port: a flat index below 128 selects way = index/16 and set = index%16. An index from 128 to 135 selects associative entry index−128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a lookup when the engine is idle |
| va_i | input | 48 | Virtual address |
| asid_i | input | 10 | Current address-space identifier |
| gps_i | input | 6 | Global page size (log2) for the set-associative part, 12 or more |
| done_o | output | 1 | One-cycle completion pulse |
| hit_o | output | 1 | The last lookup matched an entry |
| idx_o | output | 8 | Flat index of the matching entry |
| wr_en_i | input | 1 | Entry write strobe |
| wr_idx_i | input | 8 | Flat index of the entry to write |
| wr_e_i | input | 1 | Exists bit to write |
| wr_g_i | input | 1 | Global bit to write |
| wr_asid_i | input | 10 | ASID to write |
| wr_ps_i | input | 6 | Page size to write (used by associative entries) |
| wr_vppn_i | input | 35 | Tag: virtual address bits 47..13 |

## Verification
A wrong candidate counter or a wrong phase register shows up at the ports as an index in the wrong way or part, or as a hit from the associative array while a set-associative hit exists. Both are visible on the done pulse of the very lookup that goes wrong. A wrong set or shift computation shows as a miss, or as an index with the wrong set, at that same pulse. Faults in the sequencer's state show up as a missing, doubled or late done_o, or as a result that moves between lookups. The bench looks at the window after each pulse to catch these.

// File: rtl/tlb_lookup_pkg.sv
package tlb_lookup_pkg;
  localparam int VA_W    = 48;
  localparam int TAG_LSB = 13;
  localparam int TAG_W   = VA_W - TAG_LSB;
  localparam int ASID_W  = 10;
  localparam int PS_W    = 6;

  typedef struct packed {
    logic              e;
    logic              g;
    logic [ASID_W-1:0] asid;
    logic [PS_W-1:0]   ps;
    logic [TAG_W-1:0]  tag;
  } tlb_ent_t;
endpackage

// File: rtl/tlb_entry_cmp.sv
module tlb_entry_cmp
  import tlb_lookup_pkg::*;
(
  input  tlb_ent_t          ent_i,
  input  logic [PS_W-1:0]   ps_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [ASID_W-1:0] asid_i,
  output logic              hit_o
);
  logic [PS_W:0]   sh_va, sh_tag;
  logic [VA_W-1:0] tag_ext, vpn, tag_cmp;

  always_comb begin
    sh_va   = {1'b0, ps_i} + (PS_W+1)'(1);
    // the tag starts at bit TAG_LSB, so it needs a shift of ps+1-TAG_LSB
    sh_tag  = {1'b0, ps_i} - (PS_W+1)'(TAG_LSB - 1);
    tag_ext = VA_W'(ent_i.tag);
    vpn     = va_i >> sh_va;
    tag_cmp = tag_ext >> sh_tag;
    hit_o   = ent_i.e && (ent_i.g || (ent_i.asid == asid_i)) && (vpn == tag_cmp);
  end
endmodule

// File: rtl/tlb_lookup_ctrl.sv
module tlb_lookup_ctrl
  import tlb_lookup_pkg::*;
#(
  parameter int WAYS = 8,
  parameter int SETS = 16,
  parameter int FA_N = 8,
  localparam int TOTAL  = WAYS * SETS + FA_N,
  localparam int IDX_W  = $clog2(TOTAL),
  localparam int SET_W  = $clog2(SETS),
  localparam int SLOT_W = $clog2((WAYS > FA_N) ? WAYS : FA_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [PS_W-1:0]   gps_i,
  input  logic [SET_W-1:0]  set_i,
  input  logic              match_i,
  output logic              fa_sel_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [VA_W-1:0]   va_q_o,
  output logic [ASID_W-1:0] asid_q_o,
  output logic [PS_W-1:0]   gps_q_o,
  output logic              done_o,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_SA, ST_FA} st_e;
  st_e state_q;

  logic [IDX_W-1:0] sa_idx, fa_idx;
  assign sa_idx   = IDX_W'(slot_o) * IDX_W'(SETS) + IDX_W'(set_i);
  assign fa_idx   = IDX_W'(WAYS * SETS) + IDX_W'(slot_o);
  assign fa_sel_o = (state_q == ST_FA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      slot_o   <= '0;
      va_q_o   <= '0;
      asid_q_o <= '0;
      gps_q_o  <= '0;
      done_o   <= 1'b0;
      hit_o    <= 1'b0;
      idx_o    <= '0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q  <= ST_SA;
          slot_o   <= '0;
          va_q_o   <= va_i;
          asid_q_o <= asid_i;
          gps_q_o  <= gps_i;
          hit_o    <= 1'b0;
          idx_o    <= '0;
        end
        ST_SA: begin
          if (match_i) begin
            hit_o   <= 1'b1;
            idx_o   <= sa_idx;
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (slot_o == SLOT_W'(WAYS - 1)) begin
            state_q <= ST_FA;
            slot_o  <= '0;
          end else begin
            slot_o <= slot_o + SLOT_W'(1);
          end
        end
        ST_FA: begin
          if (match_i) begin
            hit_o   <= 1'b1;
            idx_o   <= fa_idx;
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (slot_o == SLOT_W'(FA_N - 1)) begin
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            slot_o <= slot_o + SLOT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlb_lookup_pkg::*;
#(
  parameter int WAYS = 8,
  parameter int SETS = 16,
  parameter int FA_N = 8,
  localparam int SA_N   = WAYS * SETS,
  localparam int TOTAL  = SA_N + FA_N,
  localparam int IDX_W  = $clog2(TOTAL),
  localparam int SET_W  = $clog2(SETS),
  localparam int SLOT_W = $clog2((WAYS > FA_N) ? WAYS : FA_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [PS_W-1:0]   gps_i,
  output logic              done_o,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_e_i,
  input  logic              wr_g_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic [PS_W-1:0]   wr_ps_i,
  input  logic [TAG_W-1:0]  wr_vppn_i
);
  tlb_ent_t sa_mem [WAYS][SETS];
  tlb_ent_t fa_mem [FA_N];
  tlb_ent_t wr_ent, cur_ent;

  logic [IDX_W-1:0]  wr_way, wr_fa;
  logic [SET_W-1:0]  wr_set, sa_set;
  logic              fa_sel, match;
  logic [SLOT_W-1:0] slot;
  logic [VA_W-1:0]   va_q;
  logic [ASID_W-1:0] asid_q;
  logic [PS_W-1:0]   gps_q, cur_ps;

  assign wr_ent = '{e: wr_e_i, g: wr_g_i, asid: wr_asid_i, ps: wr_ps_i, tag: wr_vppn_i};
  assign wr_way = wr_idx_i >> SET_W;
  assign wr_set = wr_idx_i[SET_W-1:0];
  assign wr_fa  = wr_idx_i - IDX_W'(SA_N);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < SETS; s++) sa_mem[w][s] <= '0;
      end else if (wr_en_i && (wr_idx_i < IDX_W'(SA_N)) && (wr_way == IDX_W'(w))) begin
        sa_mem[w][wr_set] <= wr_ent;
      end
    end
  end

  for (genvar i = 0; i < FA_N; i++) begin : g_fa
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fa_mem[i] <= '0;
      else if (wr_en_i && (wr_idx_i >= IDX_W'(SA_N)) && (wr_fa == IDX_W'(i)))
        fa_mem[i] <= wr_ent;
    end
  end

  // set comes from the page number under the global page size
  assign sa_set  = SET_W'(va_q >> ({1'b0, gps_q} + (PS_W+1)'(1)));
  assign cur_ent = fa_sel ? fa_mem[slot] : sa_mem[slot][sa_set];
  assign cur_ps  = fa_sel ? cur_ent.ps : gps_q;

  tlb_entry_cmp u_cmp (
    .ent_i  (cur_ent),
    .ps_i   (cur_ps),
    .va_i   (va_q),
    .asid_i (asid_q),
    .hit_o  (match)
  );

  tlb_lookup_ctrl #(.WAYS(WAYS), .SETS(SETS), .FA_N(FA_N)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .va_i     (va_i),
    .asid_i   (asid_i),
    .gps_i    (gps_i),
    .set_i    (sa_set),
    .match_i  (match),
    .fa_sel_o (fa_sel),
    .slot_o   (slot),
    .va_q_o   (va_q),
    .asid_q_o (asid_q),
    .gps_q_o  (gps_q),
    .done_o   (done_o),
    .hit_o    (hit_o),
    .idx_o    (idx_o)
  );
endmodule

// File: rtl/tlb_lookup_chk.sv
module tlb_lookup_chk #(
  parameter int WAYS = 8,
  parameter int SETS = 16,
  parameter int FA_N = 8,
  localparam int TOTAL = WAYS * SETS + FA_N,
  localparam int IDX_W = $clog2(TOTAL),
  localparam int LAT   = WAYS + FA_N
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             done_o,
  input logic             hit_o,
  input logic [IDX_W-1:0] idx_o
);
  logic        busy_q;
  logic [15:0] wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      wait_q <= '0;
    end else begin
      if (start_i && (!busy_q || done_o)) wait_q <= '0;
      else if (busy_q && wait_q != '1) wait_q <= wait_q + 16'd1;
      if (done_o) busy_q <= start_i;
      else if (start_i) busy_q <= 1'b1;
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (($stable(hit_o) && $stable(idx_o)) || done_o));
  // R8
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (wait_q <= 16'(LAT)));
  // R9
  done_needs_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_q);
  // R4
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (idx_o < IDX_W'(TOTAL)));
  // R8
  miss_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !hit_o) |-> (idx_o == '0));
endmodule

bind tlb_lookup tlb_lookup_chk #(.WAYS(WAYS), .SETS(SETS), .FA_N(FA_N)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .done_o  (done_o),
  .hit_o   (hit_o),
  .idx_o   (idx_o)
);

// File: tb/tlb_lookup_bench.sv
`timescale 1ns/1ps
module tlb_lookup_bench;
  localparam int WAYS = 8, SETS = 16, FA_N = 8;
  localparam int SA_N = WAYS * SETS;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0;
  logic [47:0] va = '0;
  logic [9:0]  asid = '0;
  logic [5:0]  gps = 6'd12;
  logic        done, hit;
  logic [7:0]  idx;
  logic        wr_en = 1'b0, wr_e = 1'b0, wr_g = 1'b0;
  logic [7:0]  wr_idx = '0;
  logic [9:0]  wr_asid = '0;
  logic [5:0]  wr_ps = '0;
  logic [34:0] wr_vppn = '0;

  int n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  tlb_lookup u_tlb_lookup (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .va_i(va), .asid_i(asid),
    .gps_i(gps), .done_o(done), .hit_o(hit), .idx_o(idx),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_e_i(wr_e), .wr_g_i(wr_g),
    .wr_asid_i(wr_asid), .wr_ps_i(wr_ps), .wr_vppn_i(wr_vppn)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] set_of(input logic [47:0] a, input int ps);
    return 4'((a >> (ps + 1)) & 48'hF);
  endfunction

  task automatic wr(input int fidx, input logic e, input logic g, input logic [9:0] as,
                    input logic [5:0] ps, input logic [47:0] a);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 8'(fidx); wr_e = e; wr_g = g; wr_asid = as;
    wr_ps = ps; wr_vppn = a[47:13];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup(input logic [47:0] a, input logic [9:0] as, input logic [5:0] ps,
                        input logic exp_hit, input int exp_idx, input string req);
    int n = 0;
    @(negedge clk);
    start = 1'b1; va = a; asid = as; gps = ps;
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
    check({req, " done seen"}, 32'(done), 32'd1);
    check({req, " R8 latency"}, 32'(n <= WAYS + FA_N), 32'd1);
    check({req, " hit"}, 32'(hit), 32'(exp_hit));
    check({req, " idx"}, 32'(idx), 32'(exp_idx));
    @(negedge clk);
    check({req, " R8 done one cycle"}, 32'(done), 32'd0);
  endtask

  localparam logic [47:0] VA_A = 48'h0000_1234_5000;
  localparam logic [47:0] VA_B = 48'h0000_8060_0000;
  localparam logic [47:0] VA_C = 48'h0000_00AB_C000;
  localparam logic [47:0] VA_D = 48'h0000_4567_8000;
  localparam logic [47:0] VA_E = 48'h0000_7777_0000;

  task automatic t_reset;
    check("R1 done after reset", 32'(done), 32'd0);
    check("R1 hit after reset", 32'(hit), 32'd0);
    check("R1 idx after reset", 32'(idx), 32'd0);
    lookup(VA_A, 10'd0, 6'd12, 1'b0, 0, "R1 empty miss");
  endtask

  task automatic t_exists;
    wr(3 * SETS + set_of(VA_A, 12), 1'b0, 1'b1, 10'd0, 6'd12, VA_A);
    lookup(VA_A, 10'd0, 6'd12, 1'b0, 0, "R2 exists clear");
    wr(3 * SETS + set_of(VA_A, 12), 1'b1, 1'b1, 10'd0, 6'd12, VA_A);
    lookup(VA_A ^ 48'h1FFF, 10'd0, 6'd12, 1'b1, 3 * SETS + set_of(VA_A, 12), "R4 R10 way3 hit");
    lookup(VA_A ^ 48'h1000, 10'd0, 6'd12, 1'b1, 3 * SETS + set_of(VA_A, 12), "R4 odd page of pair");
  endtask

  task automatic t_asid;
    wr(0 * SETS + set_of(VA_E, 12), 1'b1, 1'b0, 10'd5, 6'd12, VA_E);
    lookup(VA_E, 10'd5, 6'd12, 1'b1, set_of(VA_E, 12), "R3 asid equal");
    lookup(VA_E, 10'd6, 6'd12, 1'b0, 0, "R3 asid differs");
    wr(0 * SETS + set_of(VA_E, 12), 1'b1, 1'b1, 10'd5, 6'd12, VA_E);
    lookup(VA_E, 10'd6, 6'd12, 1'b1, set_of(VA_E, 12), "R3 global");
    wr(0 * SETS + set_of(VA_E, 12), 1'b0, 1'b0, 10'd0, 6'd12, VA_E);
  endtask

  task automatic t_gps;
    int s = set_of(VA_C, 14);
    wr(s, 1'b1, 1'b1, 10'd0, 6'd14, VA_C);
    lookup(VA_C ^ 48'h6000, 10'd0, 6'd14, 1'b1, s, "R4 gps14 tag shift");
    lookup(VA_C ^ 48'h8000, 10'd0, 6'd14, 1'b0, 0, "R4 gps14 other pair");
  endtask

  task automatic t_fa;
    wr(SA_N + 4, 1'b1, 1'b1, 10'd0, 6'd21, VA_B);
    lookup(VA_B ^ 48'h3F_F000, 10'd0, 6'd12, 1'b1, SA_N + 4, "R5 own page size");
    lookup(VA_B ^ 48'h40_0000, 10'd0, 6'd12, 1'b0, 0, "R5 outside pair");
  endtask

  task automatic t_priority;
    int s = set_of(VA_D, 12);
    wr(5 * SETS + s, 1'b1, 1'b1, 10'd0, 6'd12, VA_D);
    wr(1 * SETS + s, 1'b1, 1'b1, 10'd0, 6'd12, VA_D);
    wr(SA_N + 6, 1'b1, 1'b1, 10'd0, 6'd12, VA_D);
    wr(SA_N + 2, 1'b1, 1'b1, 10'd0, 6'd12, VA_D);
    lookup(VA_D, 10'd0, 6'd12, 1'b1, 1 * SETS + s, "R7 R6 lowest way");
    wr(1 * SETS + s, 1'b0, 1'b1, 10'd0, 6'd12, VA_D);
    lookup(VA_D, 10'd0, 6'd12, 1'b1, 5 * SETS + s, "R6 way5 over assoc");
    wr(5 * SETS + s, 1'b0, 1'b1, 10'd0, 6'd12, VA_D);
    lookup(VA_D, 10'd0, 6'd12, 1'b1, SA_N + 2, "R7 lowest assoc");
  endtask

  task automatic t_hold;
    lookup(VA_D, 10'd0, 6'd12, 1'b1, SA_N + 2, "R8 pre hold");
    va = VA_E; asid = 10'd9;
    repeat (5) @(negedge clk);
    check("R8 hit held", 32'(hit), 32'd1);
    check("R8 idx held", 32'(idx), 32'(SA_N + 2));
  endtask

  task automatic t_busy_start;
    int dones = 0;
    @(negedge clk);
    start = 1'b1; va = VA_E; asid = 10'd1; gps = 6'd12;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    start = 1'b1; va = VA_D;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 30; k++) begin
      if (done) begin
        dones++;
        check("R9 first search result hit", 32'(hit), 32'd0);
        check("R9 first search result idx", 32'(idx), 32'd0);
      end
      @(negedge clk);
    end
    check("R9 single done", 32'(dones), 32'd1);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exists();
    t_asid();
    t_gps();
    t_fa();
    t_priority();
    t_hold();
    t_busy_start();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule